// File: doc/BRIEF.md
# Shared Pin-Event Interrupt Controller

This block watches a group of input pins of one I/O port and turns selected pin events into one interrupt request for the whole group. Every pin has its own enable bit and its own sticky status flag. One 2-bit sensitivity field, common to all pins, picks the event that sets a flag: a rising edge, a falling edge, either edge, or a falling edge together with a held low level. A 2-bit software priority value, also shared by the group, is driven out to the system interrupt arbiter. When an event is detected on an enabled pin, a one-cycle wake pulse is raised so that a halted device can restart.

Software reaches four registers through a simple single-cycle bus with combinational read data. The address map is: 0 = pin enables, 1 = status flags (write 1 to clear), 2 = sensitivity in bits [1:0], 3 = group priority in bits [1:0]. The sensitivity field is protected. A write to it is accepted only while the CPU interrupt mask input is at its highest level (both bits 1). A write that changes the value throws away every pending flag, so that events seen under the old setting are not reported.

Pins are sampled through a two-stage synchronizer. Edges are found by comparing the synchronized value with a registered copy taken one clock earlier.

Top module: `pin_irq_ctrl`

## Requirements
- R1: A pin change applied just before a rising clock edge sets its status flag on the third rising edge, counting that edge, and not earlier.
- R2: With sensitivity 01, a flag is set only by a low-to-high transition of its pin. A high-to-low transition sets nothing.
- R3: With sensitivity 10, a flag is set only by a high-to-low transition of its pin. A low-to-high transition sets nothing.
- R4: With sensitivity 11, a flag is set by both transitions of its pin.
- R5: With sensitivity 00, a flag is set by a falling edge and is set again on every clock while the pin stays low. A clear of that flag written while the pin is low leaves it set, because a set in the same cycle wins over a clear.
- R6: Flags are set whether or not their pin is enabled. The interrupt output is high exactly when some pin has both its flag and its enable bit set.
- R7: Writing the flag register (address 1) clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R8: A write to the sensitivity register (address 2) while the mask input is not 11 is ignored. Both the stored sensitivity and the flags stay unchanged.
- R9: An accepted sensitivity write with a new value clears all flags. An accepted write of the current value keeps them.
- R10: The wake output pulses high for exactly one cycle for each detected event on an enabled pin. It stays low for events on disabled pins.
- R11: The priority register (address 3) reads back the value written to it, and the priority output drives that value.
- R12: After reset the enables, flags, sensitivity and priority all read 0, and the interrupt and wake outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Asynchronous pin inputs, idle high |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe, valid with select |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed register, combinational |
| cpu_mask_i | input | 2 | Current CPU interrupt mask level |
| irq_o | output | 1 | Shared group interrupt request |
| irq_prio_o | output | 2 | Group software priority sent to the arbiter |
| wake_o | output | 1 | One-cycle wake pulse on an enabled event |

## Verification
The bench builds the block with its defaults: eight pins, an 8-bit data bus and a two-stage synchronizer. With eight pins, a single byte write can set, clear and mask patterns that mix enabled and disabled pins. The two-stage chain fixes the flag latency at three edges, so the bench can check that a flag is still clear one edge before that point and set on it. With the defaults, the bench also reaches the case where a held low level re-sets a flag in the same cycle as its clear, and the case where a sensitivity change races a pending flag.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  localparam int REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] REG_ENABLE = 2'd0;
  localparam logic [REG_ADDR_W-1:0] REG_FLAGS  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] REG_SENSE  = 2'd2;
  localparam logic [REG_ADDR_W-1:0] REG_PRIO   = 2'd3;

  localparam logic [1:0] MASK_TOP = 2'b11;

  typedef enum logic [1:0] {
    SENSE_FALL_LOW = 2'b00,
    SENSE_RISE     = 2'b01,
    SENSE_FALL     = 2'b10,
    SENSE_BOTH     = 2'b11
  } sense_e;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int   NUM_PINS    = 8,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LEVEL  = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [NUM_PINS-1:0] sync_o
);

  localparam logic [NUM_PINS-1:0] RST_VAL = {NUM_PINS{IDLE_LEVEL}};

  logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    logic [NUM_PINS-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = pins_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign sync_o = stage_q[SYNC_STAGES-1];

endmodule

// File: rtl/pin_edge_detect.sv
module pin_edge_detect
  import pin_irq_pkg::*;
#(
  parameter int   NUM_PINS   = 8,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] sync_i,
  input  sense_e              sense_i,
  output logic [NUM_PINS-1:0] evt_o
);

  localparam logic [NUM_PINS-1:0] RST_VAL = {NUM_PINS{IDLE_LEVEL}};

  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] rise_w;
  logic [NUM_PINS-1:0] fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= sync_i;
  end

  assign rise_w = sync_i & ~prev_q;
  assign fall_w = ~sync_i & prev_q;

  always_comb begin
    unique case (sense_i)
      SENSE_RISE:     evt_o = rise_w;
      SENSE_FALL:     evt_o = fall_w;
      SENSE_BOTH:     evt_o = rise_w | fall_w;
      SENSE_FALL_LOW: evt_o = ~sync_i;
      default:        evt_o = '0;
    endcase
  end

endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel_i,
  input  logic                  bus_wr_i,
  input  logic [REG_ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  input  logic [1:0]            cpu_mask_i,
  input  logic [NUM_PINS-1:0]   evt_i,
  output logic [NUM_PINS-1:0]   en_o,
  output logic [NUM_PINS-1:0]   flag_o,
  output sense_e                sense_o,
  output logic [1:0]            prio_o
);

  logic [NUM_PINS-1:0] en_q,   en_d;
  logic [NUM_PINS-1:0] flag_q, flag_d;
  sense_e              sense_q, sense_d;
  logic [1:0]          prio_q, prio_d;

  logic                wr_en;
  logic                en_we, sense_we, prio_we, flag_we;
  logic                sense_chg;
  logic [NUM_PINS-1:0] clr_mask;

  assign wr_en     = bus_sel_i & bus_wr_i;
  assign en_we     = wr_en && (bus_addr_i == REG_ENABLE);
  assign flag_we   = wr_en && (bus_addr_i == REG_FLAGS);
  assign prio_we   = wr_en && (bus_addr_i == REG_PRIO);
  assign sense_we  = wr_en && (bus_addr_i == REG_SENSE) && (cpu_mask_i == MASK_TOP);
  assign sense_chg = sense_we && (sense_e'(bus_wdata_i[1:0]) != sense_q);

  always_comb begin
    en_d    = en_we    ? bus_wdata_i[NUM_PINS-1:0] : en_q;
    prio_d  = prio_we  ? bus_wdata_i[1:0]          : prio_q;
    sense_d = sense_we ? sense_e'(bus_wdata_i[1:0]) : sense_q;

    clr_mask = '0;
    if (flag_we)   clr_mask = bus_wdata_i[NUM_PINS-1:0];
    if (sense_chg) clr_mask = '1;
    flag_d = (flag_q & ~clr_mask) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      flag_q  <= '0;
      sense_q <= SENSE_FALL_LOW;
      prio_q  <= '0;
    end else begin
      en_q    <= en_d;
      flag_q  <= flag_d;
      sense_q <= sense_d;
      prio_q  <= prio_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      REG_ENABLE: bus_rdata_o[NUM_PINS-1:0] = en_q;
      REG_FLAGS:  bus_rdata_o[NUM_PINS-1:0] = flag_q;
      REG_SENSE:  bus_rdata_o[1:0]          = sense_q;
      REG_PRIO:   bus_rdata_o[1:0]          = prio_q;
      default:    bus_rdata_o               = '0;
    endcase
  end

  assign en_o    = en_q;
  assign flag_o  = flag_q;
  assign sense_o = sense_q;
  assign prio_o  = prio_q;

endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int   NUM_PINS    = 8,
  parameter int   DATA_W      = 8,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LEVEL  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pins_i,
  input  logic                  bus_sel_i,
  input  logic                  bus_wr_i,
  input  logic [REG_ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  input  logic [1:0]            cpu_mask_i,
  output logic                  irq_o,
  output logic [1:0]            irq_prio_o,
  output logic                  wake_o
);

  logic [NUM_PINS-1:0] sync_w;
  logic [NUM_PINS-1:0] evt_w;
  logic [NUM_PINS-1:0] en_w;
  logic [NUM_PINS-1:0] flag_w;
  sense_e              sense_w;

  pin_sync #(
    .NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES), .IDLE_LEVEL(IDLE_LEVEL)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .sync_o(sync_w)
  );

  pin_edge_detect #(
    .NUM_PINS(NUM_PINS), .IDLE_LEVEL(IDLE_LEVEL)
  ) u_detect (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_w), .sense_i(sense_w), .evt_o(evt_w)
  );

  pin_irq_regs #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .cpu_mask_i(cpu_mask_i), .evt_i(evt_w),
    .en_o(en_w), .flag_o(flag_w), .sense_o(sense_w), .prio_o(irq_prio_o)
  );

  assign irq_o  = |(flag_w & en_w);
  assign wake_o = |(evt_w & en_w);

endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_sel_i,
  input logic                  bus_wr_i,
  input logic [REG_ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0]     bus_wdata_i,
  input logic [1:0]            cpu_mask_i,
  input logic [NUM_PINS-1:0]   sync_w,
  input logic [NUM_PINS-1:0]   evt_w,
  input logic [NUM_PINS-1:0]   flag_w,
  input logic [1:0]            sense_w,
  input logic                  irq_o,
  input logic [1:0]            irq_prio_o,
  input logic                  wake_o
);

  logic wr;
  assign wr = bus_sel_i & bus_wr_i;

  // R7: without a flag write or a sensitivity change, no flag drops
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr && (bus_addr_i == REG_FLAGS)) && !(wr && (bus_addr_i == REG_SENSE)))
    |=> ((flag_w & $past(flag_w)) == $past(flag_w)));

  // R5: a low pin in the level mode leaves its flag set next cycle
  a_r5_level_reasserts: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_w == 2'b00) |=> (((~$past(sync_w)) & ~flag_w) == '0));

  // R8: guarded sensitivity write below the top mask level has no effect
  a_r8_sense_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (bus_addr_i == REG_SENSE) && (cpu_mask_i != 2'b11)) |=> $stable(sense_w));

  // R9: accepted new sensitivity with no event in flight empties the flags
  a_r9_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (bus_addr_i == REG_SENSE) && (cpu_mask_i == 2'b11) &&
     (bus_wdata_i[1:0] != sense_w) && (evt_w == '0)) |=> (flag_w == '0));

  // R10: a wake pulse leads to a request next cycle unless enables are rewritten
  a_r10_wake_then_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o && !(wr && (bus_addr_i == REG_ENABLE))) |=> irq_o);

  // R11: priority output only moves on a priority write
  a_r11_prio_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (bus_addr_i == REG_PRIO)) |=> $stable(irq_prio_o));

endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .cpu_mask_i(cpu_mask_i),
  .sync_w(sync_w), .evt_w(evt_w), .flag_w(flag_w), .sense_w(sense_w),
  .irq_o(irq_o), .irq_prio_o(irq_prio_o), .wake_o(wake_o)
);

// File: tb/pin_irq_ctrl_tb.sv
module pin_irq_ctrl_tb;

  localparam int NP = 8;
  localparam int DW = 8;
  localparam logic [1:0] A_EN = 2'd0, A_FLG = 2'd1, A_SNS = 2'd2, A_PRI = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '1;
  logic          sel = 1'b0, wr = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [1:0]    mask = 2'b11;
  logic          irq, wake;
  logic [1:0]    prio;

  int checks = 0;
  int fails  = 0;
  int wake_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pin_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .cpu_mask_i(mask), .irq_o(irq), .irq_prio_o(prio), .wake_o(wake)
  );

  always @(negedge clk) if (rst_n && wake) wake_cnt++;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bwrite(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bread(logic [1:0] a, output logic [DW-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic drive_pins(logic [NP-1:0] v);
    @(negedge clk);
    pins = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    bread(A_EN, d);  check("R12 enable", d, 0);
    bread(A_FLG, d); check("R12 flags", d, 0);
    bread(A_SNS, d); check("R12 sense", d, 0);
    bread(A_PRI, d); check("R12 prio", d, 0);
    check("R12 irq", irq, 0);
    check("R12 wake", wake, 0);
  endtask

  task automatic t_latency();
    logic [DW-1:0] d;
    bwrite(A_SNS, 8'h03);
    bwrite(A_FLG, 8'hFF);
    @(negedge clk);
    pins[6] = 1'b0;
    addr = A_FLG;
    @(negedge clk);
    @(negedge clk);
    bread(A_FLG, d); check("R1 flag before third edge", d[6], 0);
    @(negedge clk);
    bread(A_FLG, d); check("R1 flag on third edge", d[6], 1);
    drive_pins('1);
    bwrite(A_FLG, 8'hFF);
  endtask

  task automatic t_rise();
    logic [DW-1:0] d;
    bwrite(A_SNS, 8'h01);
    bwrite(A_FLG, 8'hFF);
    drive_pins(8'hF0);
    bread(A_FLG, d); check("R2 falling ignored", d, 0);
    drive_pins(8'hFF);
    bread(A_FLG, d); check("R2 rising sets", d, 8'h0F);
    bwrite(A_FLG, 8'hFF);
  endtask

  task automatic t_fall();
    logic [DW-1:0] d;
    bwrite(A_SNS, 8'h02);
    drive_pins(8'h0F);
    bread(A_FLG, d); check("R3 falling sets", d, 8'hF0);
    bwrite(A_FLG, 8'hFF);
    drive_pins(8'hFF);
    bread(A_FLG, d); check("R3 rising ignored", d, 0);
  endtask

  task automatic t_both();
    logic [DW-1:0] d;
    bwrite(A_SNS, 8'h03);
    drive_pins(8'hFE);
    bread(A_FLG, d); check("R4 fall sets", d, 8'h01);
    bwrite(A_FLG, 8'hFF);
    drive_pins(8'hFF);
    bread(A_FLG, d); check("R4 rise sets", d, 8'h01);
    bwrite(A_FLG, 8'hFF);
  endtask

  task automatic t_level();
    logic [DW-1:0] d;
    bwrite(A_SNS, 8'h00);
    drive_pins(8'hF7);
    bread(A_FLG, d); check("R5 low sets", d, 8'h08);
    bwrite(A_FLG, 8'h08);
    bread(A_FLG, d); check("R5 clear loses while low", d, 8'h08);
    drive_pins(8'hFF);
    bwrite(A_FLG, 8'h08);
    bread(A_FLG, d); check("R5 clear after high", d, 0);
  endtask

  task automatic t_enable_irq_w1c();
    logic [DW-1:0] d;
    bwrite(A_SNS, 8'h03);
    bwrite(A_EN, 8'h00);
    drive_pins(8'hDE);
    bread(A_FLG, d); check("R6 flags set while disabled", d, 8'h21);
    check("R6 irq low when disabled", irq, 0);
    bwrite(A_EN, 8'h20);
    check("R6 irq high with enabled flag", irq, 1);
    bwrite(A_EN, 8'h10);
    check("R6 irq low on other enable", irq, 0);
    bwrite(A_FLG, 8'h01);
    bread(A_FLG, d); check("R7 selective clear", d, 8'h20);
    drive_pins(8'hFF);
    bwrite(A_FLG, 8'hFF);
    bwrite(A_EN, 8'h00);
  endtask

  task automatic t_guard_and_change();
    logic [DW-1:0] d;
    drive_pins(8'hFB);
    bread(A_FLG, d); check("R9 setup flag", d, 8'h04);
    mask = 2'b01;
    bwrite(A_SNS, 8'h01);
    bread(A_SNS, d); check("R8 sense kept at low mask", d, 8'h03);
    bread(A_FLG, d); check("R8 flags kept at low mask", d, 8'h04);
    mask = 2'b11;
    bwrite(A_SNS, 8'h03);
    bread(A_FLG, d); check("R9 same value keeps flags", d, 8'h04);
    bwrite(A_SNS, 8'h02);
    bread(A_SNS, d); check("R9 new sense stored", d, 8'h02);
    bread(A_FLG, d); check("R9 new value clears flags", d, 0);
    drive_pins(8'hFF);
  endtask

  task automatic t_wake();
    int base;
    bwrite(A_SNS, 8'h03);
    bwrite(A_FLG, 8'hFF);
    bwrite(A_EN, 8'h04);
    base = wake_cnt;
    drive_pins(8'hFB);
    check("R10 one pulse on enabled pin", wake_cnt - base, 1);
    base = wake_cnt;
    drive_pins(8'hF9);
    check("R10 no pulse on disabled pin", wake_cnt - base, 0);
    drive_pins(8'hFF);
  endtask

  task automatic t_prio();
    logic [DW-1:0] d;
    bwrite(A_PRI, 8'h02);
    bread(A_PRI, d); check("R11 prio readback", d, 8'h02);
    check("R11 prio output", prio, 2'b10);
    bwrite(A_PRI, 8'h01);
    check("R11 prio output update", prio, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_enable_irq_w1c();
    t_guard_and_change();
    t_wake();
    t_prio();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule